// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second ALU operand. It takes a data word and shifts or rotates it in one of four ways: logical left, logical right, arithmetic right or rotate right. The amount can come from a 5-bit immediate field or from an 8-bit register value. In the immediate field, zero does not always mean "no shift". It also produces the shifter carry-out that a flag-setting instruction commits. For a rotated immediate operand the value passes through unchanged and the carry takes the value's top bit.

Operands arrive on a valid/ready stream and leave on another, through one output register stage. The block accepts an input whenever its output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output word and carry hold still. Each accepted operand appears at the output one cycle after acceptance, and operands leave in the order they arrived.

Top module: `opnd_shifter`

## Requirements
- R1: Type code 0 (LSL) by n in 1..31 gives `value << n` with carry-out = input bit (32−n). An immediate LSL amount of 0 returns the value and the incoming carry unchanged.
- R2: Type code 1 (LSR) by n in 1..31 gives `value >> n` with carry-out = input bit (n−1). An immediate LSR amount of 0 acts as a shift by 32.
- R3: A register-sourced LSL or LSR by exactly 32, or an immediate LSR of 0, gives result 0. The carry-out is input bit 0 for LSL and input bit 31 for LSR.
- R4: A register-sourced LSL or LSR by more than 32 (33..255) gives result 0 and carry-out 0.
- R5: Type code 2 (ASR) by n in 1..31 shifts right and fills with the sign bit, with carry-out = input bit (n−1). For n of 32 or more, and for an immediate amount of 0, every result bit and the carry equal input bit 31.
- R6: Type code 3 (ROR) rotates right by the amount modulo 32. The carry-out equals bit 31 of the rotated result.
- R7: An immediate ROR amount of 0 is rotate-through-carry: the word shifts right by one, the incoming carry enters bit 31, and the carry-out is input bit 0.
- R8: With `in_amt_src`=1 (register amount, all 8 bits of `in_amt`) and an amount of 0, the value and the incoming carry pass unchanged for every type code. With `in_amt_src`=0 only `in_amt[4:0]` is used.
- R9: When `in_setflags` is 0, `out_carry` equals the incoming carry, whatever the shift.
- R10: When `in_rot_imm` is 1, the value passes unshifted, and with flags enabled the carry-out is bit 31 of the value.
- R11: `out_valid` is low after reset. Each accepted operand appears exactly once, in order, one cycle after acceptance. The output holds stable while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand accepted this cycle when also valid |
| in_value | input | 32 | Word to shift |
| in_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| in_amt | input | 8 | Shift amount |
| in_amt_src | input | 1 | 0 immediate field (bits 4:0), 1 register amount (bits 7:0) |
| in_rot_imm | input | 1 | Operand is an already rotated immediate |
| in_setflags | input | 1 | Carry-out is computed rather than forwarded |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 32 | Shifted word |
| out_carry | output | 1 | Shifter carry-out |

## Verification
A fault in the amount decode shows up at the port on the very next output beat. It appears either as a wrong result for the zero-amount and exactly-32 cases or as a carry taken from a neighbouring bit. A wrong stage in the logarithmic rotator corrupts every amount that has that bit set, so a single result word mismatches one cycle after acceptance. A broken output register either loses, duplicates or changes a held beat under back-pressure. That appears as a miscompare against the ordered expectation queue, or as a stall that the drain at the end exposes.

// File: rtl/opnd_shifter_pkg.sv
`timescale 1ns/1ps
package opnd_shifter_pkg;
  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    OPM_PASS   = 2'd0,
    OPM_SHIFT  = 2'd1,
    OPM_RRX    = 2'd2,
    OPM_IMMROT = 2'd3
  } op_mode_e;
endpackage

// File: rtl/opnd_amt_decode.sv
`timescale 1ns/1ps
module opnd_amt_decode
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IMM_W = $clog2(DATA_W),
  localparam int EFF_W = (AMT_W > IMM_W + 1) ? AMT_W : IMM_W + 1
) (
  input  shift_kind_e        kind,
  input  logic [AMT_W-1:0]   amt,
  input  logic               src_reg,
  input  logic               rot_imm,
  output op_mode_e           mode,
  output logic [EFF_W-1:0]   eff_amt
);
  localparam logic [EFF_W-1:0] FULL_AMT = EFF_W'(DATA_W);

  logic [IMM_W-1:0] imm_field;
  assign imm_field = amt[IMM_W-1:0];

  always_comb begin
    mode    = OPM_PASS;
    eff_amt = '0;
    if (rot_imm) begin
      mode = OPM_IMMROT;
    end else if (!src_reg) begin
      if (imm_field == '0) begin
        case (kind)
          SHK_LSL: mode = OPM_PASS;
          SHK_ROR: mode = OPM_RRX;
          default: begin
            mode    = OPM_SHIFT;
            eff_amt = FULL_AMT;
          end
        endcase
      end else begin
        mode    = OPM_SHIFT;
        eff_amt = EFF_W'(imm_field);
      end
    end else if (amt == '0) begin
      mode = OPM_PASS;
    end else begin
      mode    = OPM_SHIFT;
      eff_amt = EFF_W'(amt);
    end
  end
endmodule

// File: rtl/opnd_rot_net.sv
`timescale 1ns/1ps
module opnd_rot_net #(
  parameter int DATA_W = 32,
  localparam int IMM_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [IMM_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [IMM_W:0][DATA_W-1:0] stage;

  assign stage[0] = din;

  generate
    for (genvar s = 0; s < IMM_W; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stage[s+1] = amt[s] ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
                                 : stage[s];
    end
  endgenerate

  assign dout = stage[IMM_W];
endmodule

// File: rtl/opnd_shift_core.sv
`timescale 1ns/1ps
module opnd_shift_core
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IMM_W = $clog2(DATA_W),
  localparam int EFF_W = (AMT_W > IMM_W + 1) ? AMT_W : IMM_W + 1
) (
  input  op_mode_e          mode,
  input  shift_kind_e       kind,
  input  logic [EFF_W-1:0]  eff_amt,
  input  logic [DATA_W-1:0] value,
  input  logic              carry_in,
  input  logic              setflags,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam logic [EFF_W-1:0]  FULL_AMT = EFF_W'(DATA_W);
  localparam logic [DATA_W-1:0] ONES     = '1;

  logic [IMM_W-1:0]  amt_lo;
  logic [IMM_W-1:0]  amt_neg;
  logic [DATA_W-1:0] rot_right;
  logic [DATA_W-1:0] rot_left;
  logic [DATA_W-1:0] mask_lo;
  logic [DATA_W-1:0] mask_hi;
  logic              in_range;
  logic              exact_full;
  logic              sign_bit;
  logic              raw_carry;

  assign amt_lo     = eff_amt[IMM_W-1:0];
  assign amt_neg    = -amt_lo;
  assign mask_lo    = ONES >> amt_lo;
  assign mask_hi    = ONES << amt_lo;
  assign in_range   = eff_amt < FULL_AMT;
  assign exact_full = eff_amt == FULL_AMT;
  assign sign_bit   = value[DATA_W-1];

  opnd_rot_net #(.DATA_W(DATA_W)) u_rot_right (
    .din  (value),
    .amt  (amt_lo),
    .dout (rot_right)
  );

  opnd_rot_net #(.DATA_W(DATA_W)) u_rot_left (
    .din  (value),
    .amt  (amt_neg),
    .dout (rot_left)
  );

  always_comb begin
    result    = value;
    raw_carry = carry_in;
    case (mode)
      OPM_PASS: begin
        result    = value;
        raw_carry = carry_in;
      end
      OPM_IMMROT: begin
        result    = value;
        raw_carry = sign_bit;
      end
      OPM_RRX: begin
        result    = {carry_in, value[DATA_W-1:1]};
        raw_carry = value[0];
      end
      default: begin
        case (kind)
          SHK_LSL: begin
            if (in_range) begin
              result    = rot_left & mask_hi;
              raw_carry = rot_left[0];
            end else begin
              result    = '0;
              raw_carry = exact_full ? value[0] : 1'b0;
            end
          end
          SHK_LSR: begin
            if (in_range) begin
              result    = rot_right & mask_lo;
              raw_carry = rot_right[DATA_W-1];
            end else begin
              result    = '0;
              raw_carry = exact_full ? sign_bit : 1'b0;
            end
          end
          SHK_ASR: begin
            if (in_range) begin
              result    = (rot_right & mask_lo) | ({DATA_W{sign_bit}} & ~mask_lo);
              raw_carry = rot_right[DATA_W-1];
            end else begin
              result    = {DATA_W{sign_bit}};
              raw_carry = sign_bit;
            end
          end
          default: begin
            result    = rot_right;
            raw_carry = rot_right[DATA_W-1];
          end
        endcase
      end
    endcase
  end

  assign carry_out = setflags ? raw_carry : carry_in;
endmodule

// File: rtl/opnd_out_stage.sv
`timescale 1ns/1ps
module opnd_out_stage #(
  parameter int DW      = 33,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          full_q;
      logic [DW-1:0] data_q;

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (in_ready) begin
          full_q <= in_valid;
          if (in_valid) data_q <= in_data;
        end
      end
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/opnd_shifter.sv
`timescale 1ns/1ps
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IMM_W  = $clog2(DATA_W),
  localparam int EFF_W  = (AMT_W > IMM_W + 1) ? AMT_W : IMM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_value,
  input  logic [1:0]        in_kind,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic              in_amt_src,
  input  logic              in_rot_imm,
  input  logic              in_setflags,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_value,
  output logic              out_carry
);
  shift_kind_e       kind;
  op_mode_e          mode;
  logic [EFF_W-1:0]  eff_amt;
  logic [DATA_W-1:0] core_value;
  logic              core_carry;

  assign kind = shift_kind_e'(in_kind);

  opnd_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
    .kind    (kind),
    .amt     (in_amt),
    .src_reg (in_amt_src),
    .rot_imm (in_rot_imm),
    .mode    (mode),
    .eff_amt (eff_amt)
  );

  opnd_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .mode      (mode),
    .kind      (kind),
    .eff_amt   (eff_amt),
    .value     (in_value),
    .carry_in  (in_carry),
    .setflags  (in_setflags),
    .result    (core_value),
    .carry_out (core_carry)
  );

  opnd_out_stage #(.DW(DATA_W + 1), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({core_carry, core_value}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  ({out_carry, out_value})
  );
endmodule

// File: rtl/opnd_shifter_chk.sv
`timescale 1ns/1ps
module opnd_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_value,
  input logic [1:0]        in_kind,
  input logic [AMT_W-1:0]  in_amt,
  input logic              in_amt_src,
  input logic              in_rot_imm,
  input logic              in_setflags,
  input logic              in_carry,
  input logic [DATA_W-1:0] core_value,
  input logic              core_carry,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_value,
  input logic              out_carry
);
  logic reg_src_shift;
  assign reg_src_shift = in_valid && in_amt_src && !in_rot_imm;

  AST_CARRY_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_setflags) |-> (core_carry == in_carry)); // R9

  AST_ROTIMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rot_imm) |-> (core_value == in_value &&
      (!in_setflags || core_carry == in_value[DATA_W-1]))); // R10

  AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_src_shift && in_amt == '0) |-> (core_value == in_value && core_carry == in_carry)); // R8

  AST_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_src_shift && !in_kind[1] && in_amt > AMT_W'(DATA_W)) |->
      (core_value == '0 && (!in_setflags || !core_carry))); // R4

  AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_src_shift && in_kind == 2'd2 && in_amt >= AMT_W'(DATA_W)) |->
      (core_value == {DATA_W{in_value[DATA_W-1]}})); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_carry))); // R11
endmodule

bind opnd_shifter opnd_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_value    (in_value),
  .in_kind     (in_kind),
  .in_amt      (in_amt),
  .in_amt_src  (in_amt_src),
  .in_rot_imm  (in_rot_imm),
  .in_setflags (in_setflags),
  .in_carry    (in_carry),
  .core_value  (core_value),
  .core_carry  (core_carry),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_value   (out_value),
  .out_carry   (out_carry)
);

// File: tb/opnd_shifter_tb_top.sv
`timescale 1ns/1ps
module opnd_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic [1:0]  in_kind = '0;
  logic [7:0]  in_amt = '0;
  logic        in_amt_src = 1'b0;
  logic        in_rot_imm = 1'b0;
  logic        in_setflags = 1'b0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_value;
  logic        out_carry;

  int vectors = 0;
  int fails = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  logic [31:0] exp_v[$];
  bit          exp_c[$];
  string       exp_t[$];

  always #5 clk = ~clk;

  opnd_shifter dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_kind(in_kind), .in_amt(in_amt),
    .in_amt_src(in_amt_src), .in_rot_imm(in_rot_imm),
    .in_setflags(in_setflags), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_carry(out_carry)
  );

  function automatic void ref_model(input logic [31:0] v, input int kind, input bit src,
                                    input int amt, input bit rot, input bit sf, input bit ci,
                                    output logic [31:0] r, output bit c, output string tag);
    bit cc;
    int n;
    if (rot) begin
      r = v; cc = v[31]; tag = "R10";
    end else begin
      n = src ? (amt & 255) : (amt & 31);
      if (n == 0 && (src || kind == 0)) begin
        r = v; cc = ci; tag = src ? "R8" : "R1";
      end else if (!src && n == 0 && kind == 3) begin
        r = {ci, v[31:1]}; cc = v[0]; tag = "R7";
      end else begin
        if (!src && n == 0) n = 32;
        case (kind)
          0: begin
            if (n < 32) begin r = v << n; cc = v[32-n]; tag = "R1"; end
            else if (n == 32) begin r = '0; cc = v[0]; tag = "R3"; end
            else begin r = '0; cc = 1'b0; tag = "R4"; end
          end
          1: begin
            if (n < 32) begin r = v >> n; cc = v[n-1]; tag = "R2"; end
            else if (n == 32) begin r = '0; cc = v[31]; tag = "R3"; end
            else begin r = '0; cc = 1'b0; tag = "R4"; end
          end
          2: begin
            if (n < 32) begin r = 32'($signed(v) >>> n); cc = v[n-1]; end
            else begin r = {32{v[31]}}; cc = v[31]; end
            tag = "R5";
          end
          default: begin
            r = (v >> (n % 32)) | (v << ((32 - (n % 32)) % 32));
            cc = r[31]; tag = "R6";
          end
        endcase
      end
    end
    if (!sf) begin c = ci; tag = {tag, " R9"}; end
    else c = cc;
  endfunction

  // Scoreboard: samples 1 ns before each rising edge
  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      if (in_valid && in_ready) begin
        logic [31:0] rv; bit rc; string tg;
        ref_model(in_value, int'(in_kind), in_amt_src, int'(in_amt), in_rot_imm,
                  in_setflags, in_carry, rv, rc, tg);
        exp_v.push_back(rv); exp_c.push_back(rc); exp_t.push_back(tg);
      end
      if (out_valid && out_ready) begin
        vectors++;
        if (exp_v.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected beat: got %h/%b expected none", out_value, out_carry);
        end else begin
          logic [31:0] ev; bit ec; string et;
          ev = exp_v.pop_front(); ec = exp_c.pop_front(); et = exp_t.pop_front();
          if (out_value !== ev || out_carry !== ec) begin
            fails++;
            $display("FAIL %s R11 value got %h exp %h, carry got %b exp %b",
                     et, out_value, ev, out_carry, ec);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) out_ready = bp_en ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic send(input logic [31:0] v, input int kind, input bit src, input int amt,
                      input bit rot, input bit sf, input bit ci);
    @(negedge clk); #1;
    in_valid = 1'b1; in_value = v; in_kind = 2'(kind); in_amt = 8'(amt);
    in_amt_src = src; in_rot_imm = rot; in_setflags = sf; in_carry = ci;
    #3;
    while (!in_ready) begin @(negedge clk); #4; end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R11 got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #4;
    vectors++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset out_valid got %b exp 0", out_valid);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1 immediate LSL zero and normal
    send(32'h8000_0001, 0, 0, 0, 0, 1, 1);
    send(32'h0800_00F1, 0, 0, 5, 0, 1, 0);
    // R2 / R3 immediate LSR zero acts as 32
    send(32'h8000_0000, 1, 0, 0, 0, 1, 0);
    send(32'h0000_0030, 1, 0, 5, 0, 1, 0);
    // R5 ASR immediate zero, negative value
    send(32'h9234_5678, 2, 0, 0, 0, 1, 0);
    send(32'h9234_5678, 2, 0, 4, 0, 1, 0);
    // R7 RRX
    send(32'h0000_0003, 3, 0, 0, 0, 1, 1);
    send(32'h0000_0002, 3, 0, 0, 0, 1, 1);
    // R8 ignored upper immediate bits and register zero
    send(32'h1234_5678, 1, 0, 8'hE4, 0, 1, 0);
    for (int k = 0; k < 4; k++) send(32'hDEAD_BEEF, k, 1, 0, 0, 1, 1);
    // R3 / R4 register exact and beyond
    send(32'h0000_0001, 0, 1, 32, 0, 1, 0);
    send(32'h8000_0000, 1, 1, 32, 0, 1, 0);
    send(32'hFFFF_FFFF, 0, 1, 33, 0, 1, 1);
    send(32'hFFFF_FFFF, 1, 1, 200, 0, 1, 1);
    send(32'h8000_0000, 2, 1, 40, 0, 1, 0);
    // R6 ROR modulo and by 32
    send(32'h0000_0010, 3, 1, 36, 0, 1, 0);
    send(32'h8000_0000, 3, 1, 32, 0, 1, 0);
    // R9 flags disabled
    send(32'hFFFF_FFFF, 1, 1, 32, 0, 0, 0);
    send(32'h0000_0001, 3, 0, 0, 0, 0, 0);
    // R10 rotated immediate
    send(32'hF000_000F, 1, 0, 7, 1, 1, 0);
    send(32'h7000_000F, 0, 1, 3, 1, 1, 1);
    // R11 random traffic under back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      int a;
      case ($urandom % 6)
        0: a = 0;
        1: a = 32;
        2: a = 31 + ($urandom % 3);
        default: a = $urandom % 256;
      endcase
      send($urandom, $urandom % 4, $urandom % 2, a, ($urandom % 10) == 0,
           ($urandom % 4) != 0, $urandom % 2);
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    bp_en = 1'b0;
    repeat (10) @(negedge clk);
    #4;
    vectors++;
    if (exp_v.size() != 0) begin
      fails++;
      $display("FAIL R11 drain got %0d pending exp 0", exp_v.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule